// File: doc/BRIEF.md
# Serially Loaded Programmable Reference Divider

This block turns a fast clock into a low-rate reference: a train of positive pulses, each one fast-clock cycle wide. The division ratio comes from a 12-bit start value that a host sends over three wires: a serial data line, a serial bit clock and a latch strobe. The bits gather in a shift register. They reach the divider only when the latch strobe copies them into a holding register.

An up-counter begins at the held start value and advances once per fast clock. When it reaches all ones, it reloads the held value and raises the output pulse for the next cycle. The output period is therefore the counter's full range minus the start value. After reset everything is zero, so the divider runs at its slowest rate (a full 4096-cycle period) until a value is latched. All three serial wires are synchronised into the fast clock domain, so the host may drive them from any slow clock.

Top module: `refdiv_top`

## Requirements
- R1: The shift register takes ser_data on each rising edge of ser_clk, most significant bit first, so the first of 12 bits lands in bit 11. Shifting alone never changes the output period.
- R2: A rising edge on ser_load copies the shift register into the holding register. From then on the pulse period is 4096 minus the held value, in fast-clock cycles.
- R3: ref_pulse is active high and lasts exactly one fast-clock cycle whenever the held value is below 4095.
- R4: A newly latched value first applies at the next counter reload. The cycle in progress ends with its old length.
- R5: After reset, ref_pulse is low and the pulse period is 4096 cycles, because the start value is zero.
- R6: A held value of 4095 makes ref_pulse high on every fast-clock cycle.
- R7: A synchronous reset during operation discards the latched value and restores the 4096-cycle period.
- R8: Between reloads the counter rises by exactly one per fast clock. It reloads only from the all-ones state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast divider clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_data | input | 1 | Serial start-value bit |
| ser_clk | input | 1 | Serial bit clock, sampled on its rising edge |
| ser_load | input | 1 | Latch strobe, acts on its rising edge |
| ref_pulse | output | 1 | One-cycle reference pulse |

## Verification
Start values are sent at the two ends of the normal range (3300 and 3830), at mid-range, at a power of two, and at values near both extremes of the 12-bit span. A mistake in the reload arithmetic, such as an off-by-one or a wrong bit order, therefore shows up as a different period for each value. A start value of 4095 separates correct saturating behaviour from a counter that wraps past all ones. Bits shifted in without a latch strobe must leave the period unchanged. A value latched in the middle of a cycle must produce one interval of the old length, then intervals of the new length. Resets, both at start-up and while the divider is running, must return it to the 4096-cycle default.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
    localparam int unsigned DEF_CNT_W       = 12;
    localparam int unsigned DEF_SYNC_STAGES = 2;

    typedef struct packed {
        logic shift;
        logic latch;
    } strobe_hist_t;
endpackage

// File: rtl/rd_sync.sv
module rd_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= pipe_d;
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/rd_loader.sv
module rd_loader
    import refdiv_pkg::*;
#(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dat_s,
    input  logic             sclk_s,
    input  logic             load_s,
    output logic [CNT_W-1:0] hold,
    output logic             load_evt
);
    typedef struct packed {
        logic [CNT_W-1:0] shreg;
        logic [CNT_W-1:0] hold;
        strobe_hist_t     prev;
    } ld_state_t;

    ld_state_t st_d, st_q;
    logic      shift_evt;

    always_comb begin
        shift_evt = sclk_s & ~st_q.prev.shift;
        load_evt  = load_s & ~st_q.prev.latch;
        st_d            = st_q;
        st_d.prev.shift = sclk_s;
        st_d.prev.latch = load_s;
        if (shift_evt) st_d.shreg = {st_q.shreg[CNT_W-2:0], dat_s};
        if (load_evt)  st_d.hold  = st_q.shreg;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign hold = st_q.hold;
endmodule

// File: rtl/rd_counter.sv
module rd_counter #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] preset,
    output logic [CNT_W-1:0] count,
    output logic             pulse
);
    localparam logic [CNT_W-1:0] FULL = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pulse;
    } ctr_state_t;

    ctr_state_t st_d, st_q;
    logic       term;

    always_comb begin
        term       = (st_q.cnt == FULL);
        st_d.pulse = term;
        st_d.cnt   = term ? preset : st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign count = st_q.cnt;
    assign pulse = st_q.pulse;
endmodule

// File: rtl/refdiv_top.sv
module refdiv_top
    import refdiv_pkg::*;
#(
    parameter int unsigned CNT_W       = DEF_CNT_W,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic ser_data,
    input  logic ser_clk,
    input  logic ser_load,
    output logic ref_pulse
);
    localparam int unsigned NUM_IN = 3;

    logic [NUM_IN-1:0] raw_in, sync_out;
    logic [CNT_W-1:0]  hold_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              load_evt;

    assign raw_in = {ser_load, ser_clk, ser_data};

    for (genvar g = 0; g < NUM_IN; g++) begin : g_sync
        rd_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst  (rst),
            .din  (raw_in[g]),
            .dout (sync_out[g])
        );
    end

    rd_loader #(.CNT_W(CNT_W)) u_loader (
        .clk      (clk),
        .rst      (rst),
        .dat_s    (sync_out[0]),
        .sclk_s   (sync_out[1]),
        .load_s   (sync_out[2]),
        .hold     (hold_q),
        .load_evt (load_evt)
    );

    rd_counter #(.CNT_W(CNT_W)) u_counter (
        .clk    (clk),
        .rst    (rst),
        .preset (hold_q),
        .count  (cnt_q),
        .pulse  (ref_pulse)
    );
endmodule

// File: rtl/refdiv_chk.sv
module refdiv_chk #(
    parameter int unsigned CNT_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             ref_pulse,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] hold_q,
    input logic             load_evt
);
    localparam logic [CNT_W-1:0] FULL = '1;

    assert_hold_on_latch_R1: assert property (@(posedge clk) disable iff (rst)
        !load_evt |=> $stable(hold_q));

    assert_reload_from_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == FULL) |=> (cnt_q == $past(hold_q)));

    assert_one_cycle_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        (ref_pulse && cnt_q != FULL) |=> !ref_pulse);

    assert_reset_state_R5: assert property (@(posedge clk)
        rst |=> (cnt_q == '0 && hold_q == '0 && !ref_pulse));

    assert_count_step_R8: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != FULL) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
endmodule

bind refdiv_top refdiv_chk #(.CNT_W(CNT_W)) u_refdiv_chk (
    .clk       (clk),
    .rst       (rst),
    .ref_pulse (ref_pulse),
    .cnt_q     (cnt_q),
    .hold_q    (hold_q),
    .load_evt  (load_evt)
);

// File: tb/test_refdiv_top.sv
`timescale 1ns/1ps
module test_refdiv_top;
    localparam int FULLP = 4096;
    localparam int LOGN  = 1024;
    localparam int NVEC  = 6;
    localparam int VEC_P [NVEC] = '{3300, 3830, 3564, 2048, 4000, 1};
    localparam int VEC_E [NVEC] = '{796, 266, 532, 2048, 96, 4095};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_data = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_load = 1'b0;
    logic ref_pulse;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int pn = 0;
    int pt [LOGN];

    always #2.5 clk = ~clk;

    refdiv_top i_refdiv_top (
        .clk(clk), .rst(rst), .ser_data(ser_data),
        .ser_clk(ser_clk), .ser_load(ser_load), .ref_pulse(ref_pulse)
    );

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (!rst && ref_pulse) begin
            pt[pn % LOGN] = cyc;
            pn = pn + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic shift_word(input int v);
        for (int i = 11; i >= 0; i--) begin
            ser_data = v[i];
            repeat (3) @(negedge clk);
            ser_clk = 1'b1;
            repeat (4) @(negedge clk);
            ser_clk = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic latch_word;
        ser_load = 1'b1;
        repeat (4) @(negedge clk);
        ser_load = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_pulses(input int k);
        int target;
        target = pn + k;
        while (pn < target) @(negedge clk);
    endtask

    function automatic int last_gap(input int back);
        return pt[(pn - back) % LOGN] - pt[(pn - back - 1) % LOGN];
    endfunction

    task automatic do_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(negedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n0;
        int hi;
        repeat (3) @(negedge clk);
        check("R5 reset pulse low", int'(ref_pulse), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R5 pulse low after reset", int'(ref_pulse), 0);
        wait_pulses(2);
        check("R5 default period", last_gap(1), FULLP);

        // R2/R3 table walk
        for (int v = 0; v < NVEC; v++) begin
            shift_word(VEC_P[v]);
            latch_word();
            wait_pulses(3);
            check($sformatf("R2 period preset %0d", VEC_P[v]), last_gap(1), VEC_E[v]);
            @(negedge clk);
            check("R3 one-cycle pulse", int'(ref_pulse), 0);
        end

        // R1: shift without latch leaves period (preset 1 -> 4095)
        shift_word(3300);
        wait_pulses(2);
        check("R1 shift without latch ignored", last_gap(1), 4095);
        // latch what was shifted: MSB-first order gives 3300 -> 796
        latch_word();
        wait_pulses(3);
        check("R1 MSB-first value latched", last_gap(1), 796);

        // R4: latch mid-cycle, old cycle completes
        wait_pulses(1);
        n0 = pn;
        shift_word(3830);
        latch_word();
        check("R4 no early pulse", pn, n0);
        wait_pulses(2);
        check("R4 old length kept", last_gap(2), 796);
        check("R4 new length next", last_gap(1), 266);

        // R6: 4095 gives continuous pulse
        shift_word(4095);
        latch_word();
        wait_pulses(2);
        hi = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            hi += int'(ref_pulse);
        end
        check("R6 pulse every cycle", hi, 8);

        // R7: mid-run reset restores default
        shift_word(3300);
        latch_word();
        wait_pulses(3);
        check("R7 pre-reset period", last_gap(1), 796);
        do_reset();
        @(negedge clk);
        check("R7 pulse low after reset", int'(ref_pulse), 0);
        wait_pulses(2);
        check("R7 default period restored", last_gap(1), FULLP);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule